// File: doc/BRIEF.md
# Parallel Flash Command Interface

This block is a synthesizable, device-side model of a byte-wide parallel flash command interface. It samples active-low chip-enable, output-enable, write-enable and hardware-reset pins on a system clock. It accepts one command byte per write cycle and runs a command state machine that decides two things: what a plain read cycle returns, and when a byte in a small internal cell array is programmed. The read data leaves on `dout` together with an output-enable flag `dout_en`. A pad ring turns that pair into a tri-state bus.

A host programs a byte with a four-write sequence: two unlock writes, a program command, then the address and data. The host may instead enter a fast-program mode, where each byte takes only two writes. A third path is the identification mode, where reads return a manufacturer code and a device code instead of array contents. Programming can only clear bits, so a cell holds the AND of its old value and every byte written to it.

States: `ST_ARRAY` (reads return cells), `ST_KEY1` (first unlock write seen), `ST_KEY2` (both unlock writes seen), `ST_PGM` (awaiting program address/data), `ST_IDENT` (identification reads), `ST_FAST` (fast-program idle), `ST_FAST_PGM` (awaiting fast program data), `ST_FAST_EXIT` (exit command seen). Transitions: ARRAY→KEY1 on 0xAA@0x555; KEY1→KEY2 on 0x55@0x2AA; KEY2→PGM, IDENT or FAST on 0xA0, 0x90 or 0x20 @0x555; PGM→ARRAY on any write (programs); IDENT→ARRAY on any write; FAST→FAST_PGM on 0xA0, FAST→FAST_EXIT on 0x90, FAST→ARRAY on 0xF0; FAST_PGM→FAST on any write (programs); FAST_EXIT→ARRAY on 0x00 or 0xF0, otherwise back to FAST; KEY1/KEY2→ARRAY on any other write.

Top module: `flash_cmd_if`

## Requirements
- R1: A read cycle is ce_n=0, oe_n=0, we_n=1 with reset_n=1. It sets dout_en=1 and, outside identification mode, puts the cell at index addr[3:0] on dout (higher address bits alias).
- R2: A write cycle is ce_n=0, we_n=0, oe_n=1 with reset_n=1. It counts as exactly one command write on its first sampled clock, however many clocks it is held.
- R3: dout_en is 0 whenever ce_n=1, oe_n=1, we_n=0 or reset_n=0.
- R4: While reset_n=0 and after its release, the machine is in ST_ARRAY and every cell reads 0xFF.
- R5: In ST_ARRAY a write other than 0xAA@0x555 leaves all cells and the read mode unchanged.
- R6: The sequence 0xAA@0x555, 0x55@0x2AA, 0xA0@0x555, D@A programs the cell at A and returns to ST_ARRAY.
- R7: After 0xAA@0x555, 0x55@0x2AA, 0x20@0x555, each pair 0xA0 then D@A programs a cell. Other writes (except 0x90 and 0xF0) are ignored and the mode is kept. The pair 0x90 then 0x00 returns to ST_ARRAY.
- R8: After 0xAA@0x555, 0x55@0x2AA, 0x90@0x555, reads return 0x01 at address 0x00000, 0xC8 at 0x00001 and 0x00 at any other address. Any write leaves this mode for ST_ARRAY without programming.
- R9: A write of 0xF0, or any write that breaks the expected sequence, returns to ST_ARRAY without programming. A byte written as program data is always taken as data, even 0xF0.
- R10: Programming stores old AND new, so bits only ever go from 1 to 0.
- R11: The third write of a sequence acts as a command only at address 0x555.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock sampling the pins |
| reset_n | input | 1 | Active-low hardware reset, asynchronous |
| ce_n | input | 1 | Active-low chip enable |
| oe_n | input | 1 | Active-low output enable |
| we_n | input | 1 | Active-low write enable |
| addr | input | 17 | Byte address |
| din | input | 8 | Write data from the host |
| dout | output | 8 | Read data toward the pad |
| dout_en | output | 1 | Drive enable for the data pads |

## Verification
The command machine is tried with complete normal and fast-program sequences. These are compared with truncated sequences, sequences that have the wrong third-cycle address, and an abort code inserted mid-sequence or used as program data. This tells a correct decoder apart from one that checks only data or only addresses. Repeated programming of one cell separates AND-merging from plain overwriting. A write held over several clocks separates edge counting from level counting. Identification reads at the two code addresses and at an aliased address separate full-address decoding from index-only decoding. Pin combinations for standby, output disable and simultaneous enables check that only a true read cycle drives the bus.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

    typedef enum logic [2:0] {
        ST_ARRAY,
        ST_KEY1,
        ST_KEY2,
        ST_PGM,
        ST_IDENT,
        ST_FAST,
        ST_FAST_PGM,
        ST_FAST_EXIT
    } cmd_state_t;

    localparam logic [10:0] KEY1_ADDR = 11'h555;
    localparam logic [10:0] KEY2_ADDR = 11'h2AA;
    localparam logic [7:0]  KEY1_DATA = 8'hAA;
    localparam logic [7:0]  KEY2_DATA = 8'h55;
    localparam logic [7:0]  OP_PGM    = 8'hA0;
    localparam logic [7:0]  OP_IDENT  = 8'h90;
    localparam logic [7:0]  OP_FAST   = 8'h20;
    localparam logic [7:0]  OP_ABORT  = 8'hF0;
    localparam logic [7:0]  OP_LEAVE  = 8'h00;

endpackage

// File: rtl/flash_pin_decode.sv
module flash_pin_decode (
    input  logic clk,
    input  logic reset_n,
    input  logic ce_n,
    input  logic oe_n,
    input  logic we_n,
    output logic wr_stb,
    output logic rd_drive
);

    logic wr_lvl;
    logic wr_lvl_q;

    // write cycle level: chip selected, write low, output disabled
    assign wr_lvl   = reset_n & ~ce_n & ~we_n & oe_n;
    assign rd_drive = reset_n & ~ce_n & ~oe_n & we_n;

    always_ff @(posedge clk or negedge reset_n) begin
        if (!reset_n) begin
            wr_lvl_q <= 1'b0;
        end else begin
            wr_lvl_q <= wr_lvl;
        end
    end

    // one command per write cycle, on its first sampled clock
    assign wr_stb = wr_lvl & ~wr_lvl_q;

endmodule

// File: rtl/flash_cmd_fsm.sv
module flash_cmd_fsm
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W = 17,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              reset_n,
    input  logic              wr_stb,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output cmd_state_t        state,
    output logic              prog_en
);

    cmd_state_t nxt;
    logic at_key1, at_key2;
    logic d_key1, d_key2, d_pgm, d_ident, d_fast, d_abort, d_leave;

    assign at_key1 = (wr_addr == ADDR_W'(KEY1_ADDR));
    assign at_key2 = (wr_addr == ADDR_W'(KEY2_ADDR));
    assign d_key1  = (wr_data == DATA_W'(KEY1_DATA));
    assign d_key2  = (wr_data == DATA_W'(KEY2_DATA));
    assign d_pgm   = (wr_data == DATA_W'(OP_PGM));
    assign d_ident = (wr_data == DATA_W'(OP_IDENT));
    assign d_fast  = (wr_data == DATA_W'(OP_FAST));
    assign d_abort = (wr_data == DATA_W'(OP_ABORT));
    assign d_leave = (wr_data == DATA_W'(OP_LEAVE));

    // state register
    always_ff @(posedge clk or negedge reset_n) begin
        if (!reset_n) begin
            state <= ST_ARRAY;
        end else begin
            state <= nxt;
        end
    end

    // next state
    always_comb begin
        nxt = state;
        if (wr_stb) begin
            unique case (state)
                ST_ARRAY:     nxt = (at_key1 && d_key1) ? ST_KEY1 : ST_ARRAY;
                ST_KEY1:      nxt = (at_key2 && d_key2) ? ST_KEY2 : ST_ARRAY;
                ST_KEY2: begin
                    if (at_key1 && d_pgm)        nxt = ST_PGM;
                    else if (at_key1 && d_ident) nxt = ST_IDENT;
                    else if (at_key1 && d_fast)  nxt = ST_FAST;
                    else                         nxt = ST_ARRAY;
                end
                ST_PGM:       nxt = ST_ARRAY;
                ST_IDENT:     nxt = ST_ARRAY;
                ST_FAST: begin
                    if (d_abort)      nxt = ST_ARRAY;
                    else if (d_pgm)   nxt = ST_FAST_PGM;
                    else if (d_ident) nxt = ST_FAST_EXIT;
                    else              nxt = ST_FAST;
                end
                ST_FAST_PGM:  nxt = ST_FAST;
                ST_FAST_EXIT: nxt = (d_leave || d_abort) ? ST_ARRAY : ST_FAST;
                default:      nxt = ST_ARRAY;
            endcase
        end
    end

    // outputs
    always_comb begin
        prog_en = wr_stb && ((state == ST_PGM) || (state == ST_FAST_PGM));
    end

endmodule

// File: rtl/flash_cell_array.sv
module flash_cell_array #(
    parameter int DATA_W  = 8,
    parameter int CELL_AW = 4
) (
    input  logic               clk,
    input  logic               reset_n,
    input  logic               prog_en,
    input  logic [CELL_AW-1:0] prog_idx,
    input  logic [DATA_W-1:0]  prog_data,
    input  logic [CELL_AW-1:0] rd_idx,
    output logic [DATA_W-1:0]  rd_data
);

    localparam int DEPTH = 1 << CELL_AW;

    logic [DATA_W-1:0] cells [DEPTH];

    always_ff @(posedge clk or negedge reset_n) begin
        if (!reset_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                cells[i] <= '1;
            end
        end else if (prog_en) begin
            // bits can only be cleared
            cells[prog_idx] <= cells[prog_idx] & prog_data;
        end
    end

    assign rd_data = cells[rd_idx];

endmodule

// File: rtl/flash_cmd_if.sv
module flash_cmd_if
    import flash_cmd_pkg::*;
#(
    parameter int              ADDR_W   = 17,
    parameter int              DATA_W   = 8,
    parameter int              CELL_AW  = 4,
    parameter logic [7:0]      MFR_CODE = 8'h01,
    parameter logic [7:0]      DEV_CODE = 8'hC8
) (
    input  logic              clk,
    input  logic              reset_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              dout_en
);

    logic              wr_stb;
    logic              rd_drive;
    logic              prog_en;
    cmd_state_t        state;
    logic [DATA_W-1:0] cell_q;
    logic [DATA_W-1:0] ident_q;

    flash_pin_decode u_pins (
        .clk      (clk),
        .reset_n  (reset_n),
        .ce_n     (ce_n),
        .oe_n     (oe_n),
        .we_n     (we_n),
        .wr_stb   (wr_stb),
        .rd_drive (rd_drive)
    );

    flash_cmd_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
        .clk     (clk),
        .reset_n (reset_n),
        .wr_stb  (wr_stb),
        .wr_addr (addr),
        .wr_data (din),
        .state   (state),
        .prog_en (prog_en)
    );

    flash_cell_array #(.DATA_W(DATA_W), .CELL_AW(CELL_AW)) u_cells (
        .clk       (clk),
        .reset_n   (reset_n),
        .prog_en   (prog_en),
        .prog_idx  (addr[CELL_AW-1:0]),
        .prog_data (din),
        .rd_idx    (addr[CELL_AW-1:0]),
        .rd_data   (cell_q)
    );

    always_comb begin
        if (addr == ADDR_W'(0))      ident_q = DATA_W'(MFR_CODE);
        else if (addr == ADDR_W'(1)) ident_q = DATA_W'(DEV_CODE);
        else                         ident_q = '0;
    end

    assign dout_en = rd_drive;
    assign dout    = !rd_drive          ? '0 :
                     (state == ST_IDENT) ? ident_q : cell_q;

endmodule

// File: rtl/flash_cmd_if_chk.sv
module flash_cmd_if_chk
    import flash_cmd_pkg::*;
#(
    parameter int         ADDR_W   = 17,
    parameter int         DATA_W   = 8,
    parameter logic [7:0] MFR_CODE = 8'h01
) (
    input logic              clk,
    input logic              reset_n,
    input logic              ce_n,
    input logic              oe_n,
    input logic              we_n,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] din,
    input logic [DATA_W-1:0] dout,
    input logic              dout_en,
    input cmd_state_t        state,
    input logic              wr_stb,
    input logic              prog_en
);

    AST_NO_DRIVE_IDLE: assert property (@(posedge clk) disable iff (!reset_n)
        (ce_n || oe_n || !we_n) |-> !dout_en); // R3

    AST_ARRAY_HOLDS: assert property (@(posedge clk) disable iff (!reset_n)
        (state == ST_ARRAY && !wr_stb) |=> (state == ST_ARRAY)); // R5

    AST_FAST_ARM: assert property (@(posedge clk) disable iff (!reset_n)
        (state == ST_FAST && wr_stb && din == DATA_W'(OP_PGM)) |=> (state == ST_FAST_PGM)); // R7

    AST_PROG_WINDOW: assert property (@(posedge clk) disable iff (!reset_n)
        prog_en |-> (state == ST_PGM || state == ST_FAST_PGM)); // R6

    AST_ABORT_ARRAY: assert property (@(posedge clk) disable iff (!reset_n)
        (wr_stb && din == DATA_W'(OP_ABORT) && state != ST_PGM && state != ST_FAST_PGM)
        |=> (state == ST_ARRAY)); // R9

    AST_IDENT_MFR: assert property (@(posedge clk) disable iff (!reset_n)
        (state == ST_IDENT && dout_en && addr == ADDR_W'(0)) |-> (dout == DATA_W'(MFR_CODE))); // R8

    AST_WRITE_ONCE: assert property (@(posedge clk) disable iff (!reset_n)
        wr_stb |=> !wr_stb); // R2

endmodule

bind flash_cmd_if flash_cmd_if_chk #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .MFR_CODE (MFR_CODE)
) chk_i (
    .clk     (clk),
    .reset_n (reset_n),
    .ce_n    (ce_n),
    .oe_n    (oe_n),
    .we_n    (we_n),
    .addr    (addr),
    .din     (din),
    .dout    (dout),
    .dout_en (dout_en),
    .state   (state),
    .wr_stb  (wr_stb),
    .prog_en (prog_en)
);

// File: tb/flash_cmd_if_tb_top.sv
`timescale 1ns/1ps
module flash_cmd_if_tb_top;

    logic        clk = 1'b0;
    logic        reset_n = 1'b0;
    logic        ce_n = 1'b1;
    logic        oe_n = 1'b1;
    logic        we_n = 1'b1;
    logic [16:0] addr = '0;
    logic [7:0]  din = '0;
    logic [7:0]  dout;
    logic        dout_en;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    flash_cmd_if dut_i (
        .clk(clk), .reset_n(reset_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .addr(addr), .din(din), .dout(dout), .dout_en(dout_en)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    // mode: 0 array, 1 key1, 2 key2, 3 program, 4 ident, 5 fast, 6 fast program, 7 fast exit
    int         m_mode = 0;
    logic [7:0] m_cell [16];
    bit         m_prev = 1'b0;

    initial for (int i = 0; i < 16; i++) m_cell[i] = 8'hFF;

    always @(posedge clk) begin
        if (!reset_n) begin
            m_mode = 0;
            m_prev = 1'b0;
            for (int i = 0; i < 16; i++) m_cell[i] = 8'hFF;
        end else begin
            bit now_wr;
            now_wr = !ce_n && !we_n && oe_n;
            if (now_wr && !m_prev) begin
                case (m_mode)
                    0: m_mode = (addr == 17'h555 && din == 8'hAA) ? 1 : 0;
                    1: m_mode = (addr == 17'h2AA && din == 8'h55) ? 2 : 0;
                    2: begin
                        if (addr != 17'h555) m_mode = 0;
                        else if (din == 8'hA0) m_mode = 3;
                        else if (din == 8'h90) m_mode = 4;
                        else if (din == 8'h20) m_mode = 5;
                        else m_mode = 0;
                    end
                    3: begin m_cell[addr % 16] = m_cell[addr % 16] & din; m_mode = 0; end
                    4: m_mode = 0;
                    5: begin
                        if (din == 8'hF0) m_mode = 0;
                        else if (din == 8'hA0) m_mode = 6;
                        else if (din == 8'h90) m_mode = 7;
                    end
                    6: begin m_cell[addr % 16] = m_cell[addr % 16] & din; m_mode = 5; end
                    default: m_mode = (din == 8'h00 || din == 8'hF0) ? 0 : 5;
                endcase
            end
            m_prev = now_wr;
        end
    end

    // compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (!done) begin
            bit         e_en;
            logic [7:0] e_d;
            e_en = reset_n && !ce_n && !oe_n && we_n;
            chk(e_en ? "R1" : "R3", {7'd0, dout_en}, {7'd0, e_en});
            if (e_en) begin
                if (m_mode == 4) e_d = (addr == 17'd0) ? 8'h01 : (addr == 17'd1) ? 8'hC8 : 8'h00;
                else             e_d = m_cell[addr % 16];
                chk(m_mode == 4 ? "R8" : "R1", dout, e_d);
            end
        end
    end

    // ---------------- stimulus tasks ----------------
    task automatic idle();
        ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1;
    endtask

    task automatic wr_hold(input logic [16:0] a, input logic [7:0] d, input int n);
        @(posedge clk); #1;
        ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b1; addr = a; din = d;
        repeat (n - 1) @(posedge clk);
        @(posedge clk); #1;
        idle();
    endtask

    task automatic wr(input logic [16:0] a, input logic [7:0] d);
        wr_hold(a, d, 1);
    endtask

    task automatic rd(input string tag, input logic [16:0] a, input logic [7:0] exp);
        @(posedge clk); #1;
        ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1; addr = a;
        @(negedge clk);
        chk(tag, {7'd0, dout_en}, 8'd1);
        chk(tag, dout, exp);
        @(posedge clk); #1;
        idle();
    endtask

    task automatic unlock();
        wr(17'h555, 8'hAA);
        wr(17'h2AA, 8'h55);
    endtask

    task automatic pins_off(input string tag, input logic c, input logic o, input logic w);
        @(posedge clk); #1;
        ce_n = c; oe_n = o; we_n = w; addr = 17'd3;
        @(negedge clk);
        chk(tag, {7'd0, dout_en}, 8'd0);
        @(posedge clk); #1;
        idle();
    endtask

    task automatic summary();
        $display("  Result: errors=%0d of %0d checks", errors, checks);
    endtask

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected finish");
            summary();
            $finish;
        end
    end

    initial begin
        // R4: reset state, bus quiet during reset
        ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R4 reset quiet", {7'd0, dout_en}, 8'd0);
        @(posedge clk); #1;
        idle();
        reset_n = 1'b1;
        rd("R4 erased after reset", 17'd3, 8'hFF);

        // R6: four-write program
        unlock(); wr(17'h555, 8'hA0); wr(17'd3, 8'h3C);
        rd("R6 programmed", 17'd3, 8'h3C);
        rd("R6 back in array mode", 17'd3, 8'h3C);

        // R10: AND merge
        unlock(); wr(17'h555, 8'hA0); wr(17'd3, 8'hF5);
        rd("R10 and-merge", 17'd3, 8'h34);

        // R5: stray writes in array mode
        wr(17'd5, 8'h00);
        rd("R5 stray write ignored", 17'd5, 8'hFF);
        wr(17'h555, 8'hA0); wr(17'd6, 8'h00);
        rd("R5 bare command ignored", 17'd6, 8'hFF);

        // R9: broken sequence
        unlock(); wr(17'h100, 8'h12); wr(17'd4, 8'h00);
        rd("R9 broken sequence", 17'd4, 8'hFF);
        rd("R9 breaking write not stored", 17'h100, 8'hFF);

        // R11: third write at wrong address
        unlock(); wr(17'h123, 8'hA0); wr(17'd4, 8'h00);
        rd("R11 wrong command address", 17'd4, 8'hFF);

        // R8: identification
        unlock(); wr(17'h555, 8'h90);
        rd("R8 manufacturer code", 17'd0, 8'h01);
        rd("R8 device code", 17'd1, 8'hC8);
        rd("R8 other address", 17'd2, 8'h00);
        rd("R8 aliased address", 17'h10000, 8'h00);
        wr(17'd0, 8'hF0);
        rd("R8 exit to array", 17'd3, 8'h34);
        rd("R8 array cell 0", 17'd0, 8'hFF);
        unlock(); wr(17'h555, 8'h90); wr(17'd7, 8'h11);
        rd("R8 any write exits, no program", 17'd7, 8'hFF);

        // R2: held write counts once
        unlock(); wr_hold(17'h555, 8'h90, 3);
        rd("R2 held write counted once", 17'd0, 8'h01);
        wr(17'd0, 8'hF0);

        // R7: fast-program mode
        unlock(); wr(17'h555, 8'h20);
        wr(17'd0, 8'hA0); wr(17'd7, 8'h81);
        rd("R7 two-write program", 17'd7, 8'h81);
        wr(17'd9, 8'h33);
        rd("R7 stray write ignored", 17'd9, 8'hFF);
        wr(17'd0, 8'hA0); wr(17'd9, 8'h5A);
        rd("R7 still in fast mode", 17'd9, 8'h5A);
        wr(17'd0, 8'h90); wr(17'd0, 8'h00);
        wr(17'd0, 8'hA0); wr(17'd10, 8'h00);
        rd("R7 exit to array", 17'd10, 8'hFF);

        // R9: abort in fast mode, abort mid-unlock, abort code as data
        unlock(); wr(17'h555, 8'h20); wr(17'd0, 8'hF0);
        wr(17'd0, 8'hA0); wr(17'd11, 8'h00);
        rd("R9 abort leaves fast mode", 17'd11, 8'hFF);
        wr(17'h555, 8'hAA); wr(17'd0, 8'hF0);
        wr(17'h2AA, 8'h55); wr(17'h555, 8'hA0); wr(17'd12, 8'h00);
        rd("R9 abort mid unlock", 17'd12, 8'hFF);
        unlock(); wr(17'h555, 8'hA0); wr(17'd12, 8'hF0);
        rd("R9 abort code taken as data", 17'd12, 8'hF0);

        // R3: pin combinations that must not drive
        pins_off("R3 output disable", 1'b0, 1'b1, 1'b1);
        pins_off("R3 standby", 1'b1, 1'b0, 1'b1);
        pins_off("R3 write and output both low", 1'b0, 1'b0, 1'b0);

        // R4: hardware reset from identification mode
        unlock(); wr(17'h555, 8'h90);
        @(posedge clk); #1;
        reset_n = 1'b0;
        @(posedge clk); #1;
        @(posedge clk); #1;
        reset_n = 1'b1;
        rd("R4 reset leaves ident mode", 17'd0, 8'hFF);
        rd("R4 reset erases cells", 17'd3, 8'hFF);

        repeat (2) @(posedge clk);
        done = 1'b1;
        summary();
        $finish;
    end

endmodule